// File: doc/BRIEF.md
# Edge-Selectable 16-bit GPIO Controller

This block is a sixteen-pin general-purpose I/O port with a single interrupt line. Software reaches it through a simple 16-bit register interface. Through that interface it sets the direction of each pin, stores the output levels and reads the sampled pin levels, gated by a per-pin enable. It also picks, for each pin, whether a rising or a falling transition counts as an event. Pin inputs pass through a two-flop synchronizer. A transition is detected by comparing the synchronized sample with the sample one clock earlier.

A detected transition on an unmasked input pin sets a sticky status bit. The interrupt line is high while any status bit is set. Software clears status bits by writing ones to them. A pin configured as an output is driven with its stored level from the cycle after the direction write. A pin turned back into an input is released.

Top module: `gpio16_edge`

## Requirements
- R1: After reset the direction and mask registers read 0xFFFF. The output data, edge select, status and pin-enable registers read 0x0000. `pad_oe` is 0 and `irq` is 0.
- R2: Registers sit at byte offsets 0x00 (sampled inputs), 0x04 (output data), 0x08 (direction), 0x0C (edge select), 0x10 (mask), 0x14 (status) and 0x18 (pin enable). Reads at any other offset return 0, and writes there have no effect.
- R3: A direction bit of 1 makes the pin an input and a 0 makes it an output. `pad_oe` bit n is high exactly when direction bit n is 0.
- R4: A write to the output data register changes `pad_out` from the next cycle, but only on output pins. Input pins drive 0 on `pad_out`.
- R5: When a direction write turns an input into an output, the stored output value appears on `pad_out` in the next cycle. When it turns an output into an input, that pin's `pad_oe` and `pad_out` drop in the next cycle.
- R6: A read at 0x00 returns the two-flop synchronized pin levels ANDed with the pin-enable register. A pin change is visible in the read after the second rising clock edge.
- R7: An edge select bit of 1 detects a 0-to-1 transition and a 0 detects a 1-to-0 transition. An event on an unmasked input pin sets its status bit, and `irq` rises, after the third rising edge following the pin change.
- R8: While a pin's mask bit is 1, its transitions set no status bit, and unmasking it later does not recover the missed event.
- R9: A write to the status register clears the bits written as 1. `irq` is low exactly when no status bit is set. An event detected in the same cycle as a clear of its bit leaves the bit set.
- R10: Writes to the sampled-input register change no register.
- R11: Pins whose direction bit is 0 never set a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | External pin levels, asynchronous |
| pad_out | output | 16 | Driven pin levels |
| pad_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The hardest case to reach is a status clear that lands in the same cycle as a new event on the same pin. Both the pin transition and the write must line up three edges apart, because of the synchronizer delay. The random phase toggles pins often while it writes the status register at random. A reference pipeline in the bench tracks the exact cycle of each event, so these collisions are both produced and checked. Further directed sequences cover masked events that are then unmasked, and transitions on pins set as outputs.

// File: rtl/gpio16_edge.sv
module gpio16_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [4:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic         irq
);
  localparam logic [4:0] A_SMP  = 5'h00;
  localparam logic [4:0] A_DAT  = 5'h04;
  localparam logic [4:0] A_DIR  = 5'h08;
  localparam logic [4:0] A_EDG  = 5'h0C;
  localparam logic [4:0] A_MSK  = 5'h10;
  localparam logic [4:0] A_STS  = 5'h14;
  localparam logic [4:0] A_PEN  = 5'h18;
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] sync1_q, sync2_q, prev_q;
  logic [W-1:0] dout_q, dir_q, edge_q, mask_q, stat_q, pen_q;
  logic [W-1:0] rise, fall, hit, clr;

  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;
  assign hit  = ((edge_q & rise) | (~edge_q & fall)) & dir_q & ~mask_q;
  assign clr  = (bus_wr && bus_addr == A_STS) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      dout_q  <= '0;
      dir_q   <= ONES;
      edge_q  <= '0;
      mask_q  <= ONES;
      stat_q  <= '0;
      pen_q   <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      stat_q  <= (stat_q & ~clr) | hit;
      if (bus_wr) begin
        case (bus_addr)
          A_DAT: dout_q <= bus_wdata;
          A_DIR: dir_q  <= bus_wdata;
          A_EDG: edge_q <= bus_wdata;
          A_MSK: mask_q <= bus_wdata;
          A_PEN: pen_q  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_SMP:   bus_rdata = sync2_q & pen_q;
      A_DAT:   bus_rdata = dout_q;
      A_DIR:   bus_rdata = dir_q;
      A_EDG:   bus_rdata = edge_q;
      A_MSK:   bus_rdata = mask_q;
      A_STS:   bus_rdata = stat_q;
      A_PEN:   bus_rdata = pen_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_oe  = ~dir_q;
  assign pad_out = dout_q & ~dir_q;
  assign irq     = |stat_q;
endmodule

// File: rtl/gpio16_edge_chk.sv
module gpio16_edge_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [4:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic         irq,
  input logic [W-1:0] mask_q
);
  // R4
  undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R3
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'h08) |=> pad_oe == ~$past(bus_wdata));

  // R4
  dout_to_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'h04) |=> pad_out == ($past(bus_wdata) & pad_oe));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_wr && bus_addr == 5'h14)) |=> irq);

  // R9
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr && bus_addr == 5'h14));

  // R8
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1 && !irq) |=> !irq);
endmodule

bind gpio16_edge gpio16_edge_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
  .mask_q(mask_q)
);

// File: tb/test_gpio16_edge.sv
`timescale 1ns/1ps
module test_gpio16_edge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_s1, m_s2, m_pv, m_dout, m_dir, m_edge, m_mask, m_stat, m_pen;

  always #2 clk = ~clk;

  gpio16_edge i_gpio16_edge (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_s2 & m_pen;
      5'h04: return m_dout;
      5'h08: return m_dir;
      5'h0C: return m_edge;
      5'h10: return m_mask;
      5'h14: return m_stat;
      5'h18: return m_pen;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic m_reset();
    m_s1 = '0; m_s2 = '0; m_pv = '0; m_dout = '0; m_dir = '1;
    m_edge = '0; m_mask = '1; m_stat = '0; m_pen = '0;
  endtask

  task automatic step(input string tag, input bit wr, input logic [4:0] a,
                      input logic [15:0] wd, input logic [15:0] pin);
    logic [15:0] hit;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; pad_in = pin;
    @(posedge clk);
    hit = ((m_edge & m_s2 & ~m_pv) | (~m_edge & ~m_s2 & m_pv)) & m_dir & ~m_mask;
    m_stat = ((wr && a == 5'h14) ? (m_stat & ~wd) : m_stat) | hit;
    m_pv = m_s2; m_s2 = m_s1; m_s1 = pin;
    if (wr) begin
      case (a)
        5'h04: m_dout = wd;
        5'h08: m_dir  = wd;
        5'h0C: m_edge = wd;
        5'h10: m_mask = wd;
        5'h18: m_pen  = wd;
        default: ;
      endcase
    end
    #1;
    chk({tag, " irq"}, {15'd0, irq}, {15'd0, m_stat != 0});
    chk({tag, " pad_oe"}, pad_oe, ~m_dir);
    chk({tag, " pad_out"}, pad_out, m_dout & ~m_dir);
    if (!wr) chk({tag, " rdata"}, bus_rdata, m_read(a));
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [15:0] pin);
    step(tag, 1'b0, a, 16'h0, pin);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] pin;
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq at reset", {15'd0, irq}, 16'h0);
    chk("R1 pad_oe at reset", pad_oe, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 32; a += 4) rd("R1 R2 reset map", 5'(a), 16'h0);
    chk("R1 dir value", m_read(5'h08), 16'hFFFF);

    // R2 unmapped write ignored, R10 write to sampled register ignored
    step("R2 unmapped wr", 1'b1, 5'h1C, 16'hFFFF, 16'h0);
    rd("R2 unmapped rd", 5'h1C, 16'h0);
    step("R10 wr smp", 1'b1, 5'h00, 16'hFFFF, 16'h0);
    rd("R10 smp rd", 5'h00, 16'h0);
    for (int a = 4; a < 28; a += 4) rd("R10 regs unchanged", 5'(a), 16'h0);

    // R6 sync latency
    step("R6 pen", 1'b1, 5'h18, 16'hFFFF, 16'h0);
    rd("R6 t0", 5'h00, 16'h00A5);
    chk("R6 after 1 edge", bus_rdata, 16'h0000);
    rd("R6 t1", 5'h00, 16'h00A5);
    chk("R6 after 2 edges", bus_rdata, 16'h00A5);
    step("R6 pen partial", 1'b1, 5'h18, 16'h000F, 16'h00A5);
    rd("R6 gated", 5'h00, 16'h00A5);
    chk("R6 gated value", bus_rdata, 16'h0005);
    step("R6 pen all", 1'b1, 5'h18, 16'hFFFF, 16'h0);
    repeat (3) rd("R6 settle", 5'h14, 16'h0);

    // R7 rising edge on pin 0, latency of three edges
    step("R7 edge", 1'b1, 5'h0C, 16'h0001, 16'h0);
    step("R7 mask", 1'b1, 5'h10, 16'hFFFC, 16'h0);
    rd("R7 e1", 5'h14, 16'h0001);
    chk("R7 no irq after 1", {15'd0, irq}, 16'h0);
    rd("R7 e2", 5'h14, 16'h0001);
    chk("R7 no irq after 2", {15'd0, irq}, 16'h0);
    rd("R7 e3", 5'h14, 16'h0001);
    chk("R7 irq after 3", {15'd0, irq}, 16'h1);
    chk("R7 status bit0", bus_rdata, 16'h0001);
    // R7 falling edge on pin 1: none from pin 0 falling
    rd("R7 p1 hi", 5'h14, 16'h0002);
    repeat (3) rd("R7 p1 hi", 5'h14, 16'h0002);
    step("R9 clr", 1'b1, 5'h14, 16'h0001, 16'h0002);
    rd("R9 cleared", 5'h14, 16'h0002);
    chk("R9 irq low", {15'd0, irq}, 16'h0);
    repeat (3) rd("R7 p1 fall", 5'h14, 16'h0000);
    chk("R7 falling sets bit1", bus_rdata, 16'h0002);
    step("R9 clr all", 1'b1, 5'h14, 16'hFFFF, 16'h0);

    // R9 collision: clear in the cycle the event on pin 0 is detected
    rd("R9 c0", 5'h14, 16'h0001);
    rd("R9 c1", 5'h14, 16'h0001);
    step("R9 collide", 1'b1, 5'h14, 16'h0001, 16'h0001);
    rd("R9 collide rd", 5'h14, 16'h0001);
    chk("R9 set wins", bus_rdata, 16'h0001);
    step("R9 clr", 1'b1, 5'h14, 16'hFFFF, 16'h0000);

    // R8 masked pin 4 toggles, then unmask
    repeat (3) rd("R8 q", 5'h14, 16'h0000);
    step("R8 clr", 1'b1, 5'h14, 16'hFFFF, 16'h0);
    step("R8 edge4", 1'b1, 5'h0C, 16'h0010, 16'h0010);
    repeat (4) rd("R8 masked", 5'h14, 16'h0010);
    step("R8 unmask", 1'b1, 5'h10, 16'h0000, 16'h0010);
    repeat (3) rd("R8 after unmask", 5'h14, 16'h0010);
    chk("R8 no late status", bus_rdata, 16'h0000);

    // R11 output pin 4 toggling, R4 R5 drive
    step("R4 dout", 1'b1, 5'h04, 16'h0013, 16'h0010);
    chk("R4 inputs undriven", pad_out, 16'h0000);
    step("R5 dir", 1'b1, 5'h08, 16'hFFEF, 16'h0010);
    chk("R5 immediate drive", pad_out, 16'h0010);
    chk("R3 oe", pad_oe, 16'h0010);
    repeat (4) rd("R11 out pin", 5'h14, 16'h0000);
    repeat (4) rd("R11 out pin", 5'h14, 16'h0010);
    chk("R11 no status", bus_rdata, 16'h0000);
    step("R5 release", 1'b1, 5'h08, 16'hFFFF, 16'h0010);
    chk("R5 released", pad_oe, 16'h0000);
    chk("R5 released out", pad_out, 16'h0000);

    // random phase
    pin = 16'h0010;
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 16;
      logic [4:0] a = 5'($urandom % 8) << 2;
      logic [15:0] wd = 16'($urandom);
      if ($urandom % 3 == 0) pin = pin ^ (16'(1) << ($urandom % 16));
      if (a == 5'h10) wd = wd & 16'($urandom);
      if (r < 4) step("R3 R4 R7 R9 random wr", 1'b1, a, wd, pin);
      else rd("R6 R7 R8 R9 random rd", (r < 10) ? 5'h14 : a, pin);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule